// File: doc/BRIEF.md
# Trinomial-Field Serial Multiplier with Rotated Mode

This block multiplies two elements of GF(2^M) held in polynomial basis, where the field is generated by an irreducible trinomial x^M + x^N + 1 (M > N > 0, both parameters). The multiplier is bit-serial in A: after a start strobe it takes one coefficient of A per clock, lowest first. It adds the current multiple x^i·B mod P into an accumulator whenever that coefficient is one, and then advances the multiple by one multiply-by-x step in a feedback shift register.

A single mode input chooses between two reduction identities that share the same register and accumulator. With mode 0 the feedback uses x^M = x^N + 1 and the product comes out in natural bit order. With mode 1 the operand is loaded rotated and the feedback uses x^N = x^M + 1, so the product comes out cyclically rotated by N positions. A wrapper can run both modes on the same operands and compare the results to detect faults. That comparison lives outside this block.

The result and the done strobe are registered. The result keeps its value until the next completion.

Top module: `gf_trinomial_mul`

## Requirements
- R1: While reset is high, and on the first cycle after it, done is 0 and result is all zeros.
- R2: With mode 0, result equals A·B reduced modulo x^M + x^N + 1. Bit i of a_in, b_in and result is the coefficient of x^i.
- R3: With mode 1 and the same operands, result bit i equals bit (i+N) mod M of the mode-0 product.
- R4: When start is sampled while the block is idle, done rises exactly M clock edges later and stays high for exactly one cycle. The new result is valid in that cycle.
- R5: A start strobe that arrives while a multiplication is in progress is ignored. The running operation completes with its original operands and mode, and no extra done pulse follows.
- R6: result changes only in the cycle where done is high. Otherwise it holds its previous value.
- R7: Behaviour per R2 to R4 holds for trinomials with M = 2N, with M > 2N and with M < 2N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication; operands and mode are sampled with it |
| mode | input | 1 | 0: natural-order product, 1: product rotated by N |
| a_in | input | M | Multiplier operand A, bit i is coefficient of x^i |
| b_in | input | M | Multiplicand operand B, bit i is coefficient of x^i |
| done | output | 1 | One-cycle pulse marking a fresh result |
| result | output | M | Product in the order selected by mode |

## Verification
The bench builds three small fields side by side: x^5+x^2+1 (M > 2N), x^5+x^3+1 (M < 2N) and x^6+x^3+1 (M = 2N). Fields this small allow every pair of operands to be applied in both modes. This reaches every feedback path, including a tap on either side of the middle of the register and the case where the two taps meet at the midpoint. Each product is compared against a carry-less multiply with reduction, and the rotated mode is checked against that same reference. The latency, the single-cycle done, result holding and the ignoring of a start during a run are checked on every field.

// File: rtl/gf_trinomial_pkg.sv
package gf_trinomial_pkg;

  typedef enum logic {
    RED_TOP_FOLD = 1'b0,  // x^M = x^N + 1, natural order
    RED_MID_FOLD = 1'b1   // x^N = x^M + 1, rotated by N
  } red_mode_e;

  // width of a counter that must hold values 0 .. limit
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/gf_step_ctrl.sv
module gf_step_ctrl #(
  parameter int M = 233
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step_en,
  output logic last_step,
  output logic running,
  output logic [gf_trinomial_pkg::cnt_width(M-1)-1:0] step_idx
);
  localparam int CW = gf_trinomial_pkg::cnt_width(M-1);
  localparam logic [CW-1:0] LAST = CW'(M - 1);

  assign load      = start && !running;
  assign step_en   = running;
  assign last_step = running && (step_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      step_idx <= '0;
    end else if (load) begin
      running  <= 1'b1;
      step_idx <= '0;
    end else if (running) begin
      if (step_idx == LAST) begin
        running  <= 1'b0;
        step_idx <= '0;
      end else begin
        step_idx <= step_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/gf_operand_shifter.sv
module gf_operand_shifter #(
  parameter int M = 233,
  parameter int N = 74
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         load_mode,
  input  logic [M-1:0] b_in,
  input  logic         shift,
  input  logic         shift_mode,
  output logic [M-1:0] d_q
);
  localparam int SRC_HI  = M - 1;      // extra feedback source, mode 0
  localparam int SRC_MID = M - N - 1;  // extra feedback source, mode 1

  logic [M-1:0] load_val;
  logic [M-1:0] d_next;

  for (genvar k = 0; k < M; k++) begin : g_bit
    localparam int ROT_SRC = (k == 0) ? M - 1 : k - 1;
    localparam int LD_SRC  = (k + N) % M;

    assign load_val[k] = load_mode ? b_in[LD_SRC] : b_in[k];

    if (k == 0) begin : g_tap_low
      assign d_next[k] = d_q[ROT_SRC] ^ (shift_mode & d_q[SRC_MID]);
    end else if (k == N) begin : g_tap_mid
      assign d_next[k] = d_q[ROT_SRC] ^ (~shift_mode & d_q[SRC_HI]);
    end else begin : g_plain
      assign d_next[k] = d_q[ROT_SRC];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        d_q <= '0;
    else if (load)  d_q <= load_val;
    else if (shift) d_q <= d_next;
  end

endmodule

// File: rtl/gf_coef_accum.sv
module gf_coef_accum #(
  parameter int M = 233
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         en,
  input  logic         coef,
  input  logic [M-1:0] operand,
  output logic [M-1:0] acc_next
);
  logic [M-1:0] acc_q;

  assign acc_next = acc_q ^ ({M{coef}} & operand);

  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (en)    acc_q <= acc_next;
  end

endmodule

// File: rtl/gf_trinomial_mul.sv
module gf_trinomial_mul #(
  parameter int M = 233,
  parameter int N = 74
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         mode,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic         done,
  output logic [M-1:0] result
);
  localparam int CW = gf_trinomial_pkg::cnt_width(M-1);

  logic          load, step_en, last_step, running;
  logic [CW-1:0] step_idx;
  logic [M-1:0]  a_sr;
  logic          mode_q;
  logic [M-1:0]  d_q;
  logic [M-1:0]  acc_next;

  gf_step_ctrl #(.M(M)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step_en(step_en), .last_step(last_step),
    .running(running), .step_idx(step_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sr   <= '0;
      mode_q <= gf_trinomial_pkg::RED_TOP_FOLD;
    end else if (load) begin
      a_sr   <= a_in;
      mode_q <= mode;
    end else if (step_en) begin
      a_sr   <= a_sr >> 1;
    end
  end

  gf_operand_shifter #(.M(M), .N(N)) u_shift (
    .clk(clk), .rst(rst),
    .load(load), .load_mode(mode), .b_in(b_in),
    .shift(step_en), .shift_mode(mode_q),
    .d_q(d_q)
  );

  gf_coef_accum #(.M(M)) u_acc (
    .clk(clk), .rst(rst),
    .clear(load), .en(step_en), .coef(a_sr[0]),
    .operand(d_q), .acc_next(acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= last_step;
      if (last_step) result <= acc_next;
    end
  end

endmodule

// File: rtl/gf_trinomial_mul_chk.sv
module gf_trinomial_mul_chk #(
  parameter int M = 233,
  parameter int N = 74
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         done,
  input logic [M-1:0] result,
  input logic         running,
  input logic [gf_trinomial_pkg::cnt_width(M-1)-1:0] step_idx
);
  localparam int CW = gf_trinomial_pkg::cnt_width(M-1);
  localparam int LW = gf_trinomial_pkg::cnt_width(M+1);
  localparam logic [CW-1:0] LAST = CW'(M - 1);

  logic [LW-1:0] lat;

  always_ff @(posedge clk) begin
    if (rst)                    lat <= '0;
    else if (start && !running) lat <= '0;
    else if (running)           lat <= lat + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!done && result == '0)); // R1

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat == LW'(M))); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (running && start && step_idx != LAST) |=> (running && step_idx == $past(step_idx) + 1'b1)); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R6

endmodule

bind gf_trinomial_mul gf_trinomial_mul_chk #(.M(M), .N(N)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .result(result),
  .running(running), .step_idx(step_idx)
);

// File: tb/gf_trinomial_mul_test.sv
module gf_field_sweep #(
  parameter int M = 5,
  parameter int N = 2
) (
  input  logic clk,
  input  logic rst,
  output logic finished,
  output int   n_chk,
  output int   n_bad
);
  logic         start, mode;
  logic [M-1:0] a_in, b_in, result;
  logic         done;

  gf_trinomial_mul #(.M(M), .N(N)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .a_in(a_in), .b_in(b_in), .done(done), .result(result)
  );

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] acc, t;
    logic         top;
    acc = '0;
    t   = b;
    for (int i = 0; i < M; i++) begin
      if (a[i]) acc = acc ^ t;
      top = t[M-1];
      t   = t << 1;
      if (top) t = t ^ ((M'(1) << N) | M'(1));
    end
    return acc;
  endfunction

  function automatic logic [M-1:0] rot_n(input logic [M-1:0] c);
    logic [M-1:0] r;
    for (int i = 0; i < M; i++) r[i] = c[(i + N) % M];
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s M=%0d N=%0d actual=%h expected=%h", req, M, N, act, exp);
    end
  endtask

  task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b, input logic md,
                        output logic [M-1:0] res, output int lat);
    @(negedge clk);
    a_in = a; b_in = b; mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a_in = '0; b_in = '0; mode = 1'b0;
    lat = 0;
    while (!done && lat < M + 4) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  initial begin
    logic [M-1:0] res, held, exp0;
    int lat;
    finished = 1'b0;
    n_chk = 0; n_bad = 0;
    start = 1'b0; mode = 1'b0; a_in = '0; b_in = '0;
    @(negedge clk);
    // R1: outputs cleared during reset
    check(done == 1'b0 && result == '0, "R1", result, '0);
    while (rst) @(negedge clk);
    check(done == 1'b0 && result == '0, "R1", result, '0);

    for (int a = 0; a < (1 << M); a++) begin
      for (int b = 0; b < (1 << M); b++) begin
        exp0 = ref_mul(M'(a), M'(b));
        run_op(M'(a), M'(b), 1'b0, res, lat);
        check(res == exp0, "R2/R7 mode0 product", res, exp0);
        check(lat == M, "R4 latency", M'(lat), M'(M));
        run_op(M'(a), M'(b), 1'b1, res, lat);
        check(res == rot_n(exp0), "R3/R7 mode1 rotated product", res, rot_n(exp0));
        @(negedge clk);
        // R4 single-cycle done, R6 result holds afterwards
        check(done == 1'b0, "R4 done pulse width", M'(done), '0);
        check(result == res, "R6 result hold", result, res);
      end
    end

    // R5: a second start mid-run is ignored
    exp0 = ref_mul(M'(3), M'(M'(1) << (M - 1)));
    @(negedge clk);
    a_in = M'(3); b_in = M'(1) << (M - 1); mode = 1'b0; start = 1'b1;
    @(negedge clk);
    a_in = '1; b_in = '1; mode = 1'b1; start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < M + 4) begin
      @(negedge clk);
      lat++;
    end
    check(res == res && result == exp0, "R5 restart ignored (value)", result, exp0);
    check(lat == M, "R5 restart ignored (timing)", M'(lat), M'(M));
    held = result;
    for (int k = 0; k < M + 2; k++) begin
      @(negedge clk);
      check(done == 1'b0, "R5 no extra done", M'(done), '0);
      check(result == held, "R6 result hold after run", result, held);
    end
    finished = 1'b1;
  end

endmodule

module gf_trinomial_mul_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic fin_a, fin_b, fin_c;
  int   chk_a, chk_b, chk_c, bad_a, bad_b, bad_c;

  gf_field_sweep #(.M(5), .N(2)) u_wide_gap  (.clk(clk), .rst(rst), .finished(fin_a), .n_chk(chk_a), .n_bad(bad_a));
  gf_field_sweep #(.M(5), .N(3)) u_near_top  (.clk(clk), .rst(rst), .finished(fin_b), .n_chk(chk_b), .n_bad(bad_b));
  gf_field_sweep #(.M(6), .N(3)) u_midpoint  (.clk(clk), .rst(rst), .finished(fin_c), .n_chk(chk_c), .n_bad(bad_c));

  initial begin
    int cycles;
    int extra_bad;
    extra_bad = 0;
    cycles = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    while (!(fin_a && fin_b && fin_c) && cycles < MAX_CYCLES) begin
      @(posedge clk);
      cycles++;
    end
    if (!(fin_a && fin_b && fin_c)) begin
      extra_bad = 1;
      $display("FAIL watchdog: run did not complete in %0d cycles (all requirements)", MAX_CYCLES);
    end
    $display("== %0d vectors applied, %0d miscompares ==",
             chk_a + chk_b + chk_c + extra_bad, bad_a + bad_b + bad_c + extra_bad);
    $finish;
  end
endmodule